// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block is a small word-addressed memory shared by several requesters. Every request names one operation, a word address and up to two operands. The unit runs each operation as a single read followed by a single write, and no other requester can reach the memory between the two. This makes it suitable as the backing store for locks, counters and lock-free queues. The response carries the word as it was before the operation, together with a status bit.

A round-robin arbiter admits one request at a time. A requester raises its valid line with its fields held stable. In the cycle its grant line is high, the unit samples the address and reads the word. In the next cycle the unit writes the new value, if there is one, and presents the response to that requester. Requests that lose arbitration wait. Priority then starts from the requester after the one just served.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset every word reads as zero, and no grant or response line is high.
- R2: A request granted in one cycle gets its response, with its own response line high, in the very next cycle. The unit starts at most one operation every two cycles.
- R3: Opcode 000 (load) returns the addressed word and leaves memory unchanged.
- R4: Opcode 001 (store) writes operand A and returns the previous word.
- R5: Opcode 010 (test-and-set) returns the previous word. It writes 1 only when that word was zero, and otherwise leaves memory unchanged.
- R6: Opcode 011 (swap) writes operand A and returns the previous word.
- R7: Opcode 100 (fetch-and-add) returns the previous word and writes the previous word plus operand A, wrapping modulo 2^DATA_W.
- R8: Opcode 101 (compare-and-swap) writes operand B when the word equals operand A. It then returns the previous word with the status bit at 1.
- R9: A compare-and-swap whose operand A differs from the word leaves memory unchanged and returns the word with the status bit at 0. Every other operation reports status 1.
- R10: Grants rotate round-robin. After requester k completes, the search for the next grant starts at requester k+1, wrapping to 0 after the last.
- R11: No grant is issued while an operation is in its write cycle. Concurrent fetch-and-adds to one word from all requesters therefore each see a distinct old value, and the final word counts all of them.
- R12: Unused opcodes 110 and 111 behave as a load: they return the word, write nothing and report status 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | N_REQ | Per-requester request line, held until granted |
| req_op | input | 3*N_REQ | Per-requester opcode, 3 bits each |
| req_addr | input | ADDR_W*N_REQ | Per-requester word address |
| req_opa | input | DATA_W*N_REQ | Operand A: store/swap data, addend, or expected value |
| req_opb | input | DATA_W*N_REQ | Operand B: new value for compare-and-swap |
| req_gnt | output | N_REQ | One-hot grant; fields are sampled in this cycle |
| rsp_valid | output | N_REQ | One-hot response strobe for the served requester |
| rsp_data | output | DATA_W | Word value before the operation |
| rsp_ok | output | 1 | Status; 0 only for a failed compare-and-swap |

## Verification
The hardest case to reach is contention. Several requesters must target the same word while the arbiter pointer sits at an arbitrary position, because only then do rotation order and atomicity both show up at the ports. To get there, the stimulus first steers the pointer with single operations from chosen requesters. It then raises all requests, or a sparse subset of them, on the same edge, each a fetch-and-add to one counter word. The expected grant order and the distinct old values are predicted from the rotation rule, and a final load confirms that no increment was lost.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  localparam int OPW = 3;

  localparam logic [OPW-1:0] OP_LOAD  = 3'b000;
  localparam logic [OPW-1:0] OP_STORE = 3'b001;
  localparam logic [OPW-1:0] OP_TAS   = 3'b010;
  localparam logic [OPW-1:0] OP_SWAP  = 3'b011;
  localparam logic [OPW-1:0] OP_FADD  = 3'b100;
  localparam logic [OPW-1:0] OP_CAS   = 3'b101;

  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } rmw_phase_e;
endpackage

// File: rtl/rmw_rst_sync.sv
module rmw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rmw_rr_arbiter.sv
module rmw_rr_arbiter #(
  parameter int N_REQ = 4,
  localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  input  logic             arb_en,
  input  logic             adv_en,
  input  logic [IW-1:0]    adv_idx,
  output logic [N_REQ-1:0] gnt,
  output logic [IW-1:0]    gnt_idx,
  output logic             gnt_any
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] ptr_d;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 0; k < N_REQ; k++) begin
      int cand;
      cand = (int'(ptr_q) + k) % N_REQ;
      if (arb_en && !gnt_any && req[cand]) begin
        gnt_any   = 1'b1;
        gnt[cand] = 1'b1;
        gnt_idx   = IW'(cand);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv_en) begin
      if (adv_idx == IW'(N_REQ - 1)) ptr_d = '0;
      else                           ptr_d = adv_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (adv_en) ptr_q <= ptr_d;
  end

  // R10
  gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~req) == '0));

  // R10
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] new_val,
  output logic              wr_en,
  output logic              status_ok
);
  import atomic_rmw_pkg::*;

  always_comb begin
    new_val   = old_val;
    wr_en     = 1'b0;
    status_ok = 1'b1;
    case (op)
      OP_STORE, OP_SWAP: begin
        new_val = opa;
        wr_en   = 1'b1;
      end
      OP_TAS: begin
        new_val = {{(DATA_W-1){1'b0}}, 1'b1};
        wr_en   = (old_val == '0);
      end
      OP_FADD: begin
        new_val = old_val + opa;
        wr_en   = 1'b1;
      end
      OP_CAS: begin
        new_val   = opb;
        wr_en     = (old_val == opa);
        status_ok = (old_val == opa);
      end
      default: begin
        new_val = old_val;
      end
    endcase
  end
endmodule

// File: rtl/rmw_word_store.sv
module rmw_word_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[w] <= '0;
      else if (hit) word_q[w] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_addr];
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int N_REQ  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int OPW = 3,
  localparam int IW  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REQ-1:0]        req_valid,
  input  logic [N_REQ*OPW-1:0]    req_op,
  input  logic [N_REQ*ADDR_W-1:0] req_addr,
  input  logic [N_REQ*DATA_W-1:0] req_opa,
  input  logic [N_REQ*DATA_W-1:0] req_opb,
  output logic [N_REQ-1:0]        req_gnt,
  output logic [N_REQ-1:0]        rsp_valid,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    rsp_ok
);
  import atomic_rmw_pkg::*;

  logic rst_i_n;

  rmw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  rmw_phase_e phase_q, phase_d;
  logic [IW-1:0]     sel_q, sel_d;
  logic [OPW-1:0]    op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] opa_q, opa_d;
  logic [DATA_W-1:0] opb_q, opb_d;
  logic [DATA_W-1:0] old_q, old_d;
  logic              cap_en;

  logic [N_REQ-1:0]  gnt;
  logic [IW-1:0]     gnt_idx;
  logic              gnt_any;
  logic              in_write;

  logic [OPW-1:0]    win_op;
  logic [ADDR_W-1:0] win_addr;
  logic [DATA_W-1:0] win_opa;
  logic [DATA_W-1:0] win_opb;

  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] alu_new;
  logic              alu_we;
  logic              alu_ok;
  logic              mem_we;

  assign in_write = (phase_q == PH_WRITE);

  rmw_rr_arbiter #(.N_REQ(N_REQ)) u_arb (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .req     (req_valid),
    .arb_en  (!in_write),
    .adv_en  (in_write),
    .adv_idx (sel_q),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  always_comb begin
    win_op   = '0;
    win_addr = '0;
    win_opa  = '0;
    win_opb  = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (gnt[i]) begin
        win_op   = req_op[i*OPW +: OPW];
        win_addr = req_addr[i*ADDR_W +: ADDR_W];
        win_opa  = req_opa[i*DATA_W +: DATA_W];
        win_opb  = req_opb[i*DATA_W +: DATA_W];
      end
    end
  end

  rmw_word_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .rd_addr (win_addr),
    .rd_data (rd_data),
    .wr_en   (mem_we),
    .wr_addr (addr_q),
    .wr_data (alu_new)
  );

  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op        (op_q),
    .old_val   (old_q),
    .opa       (opa_q),
    .opb       (opb_q),
    .new_val   (alu_new),
    .wr_en     (alu_we),
    .status_ok (alu_ok)
  );

  assign mem_we = in_write && alu_we;

  // next state
  always_comb begin
    cap_en  = !in_write && gnt_any;
    phase_d = phase_q;
    sel_d   = sel_q;
    op_d    = op_q;
    addr_d  = addr_q;
    opa_d   = opa_q;
    opb_d   = opb_q;
    old_d   = old_q;
    if (in_write) begin
      phase_d = PH_READ;
    end else if (gnt_any) begin
      phase_d = PH_WRITE;
      sel_d   = gnt_idx;
      op_d    = win_op;
      addr_d  = win_addr;
      opa_d   = win_opa;
      opb_d   = win_opb;
      old_d   = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_READ;
    else if (!rst_i_n) phase_q <= PH_READ;
    else phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      op_q   <= '0;
      addr_q <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      old_q  <= '0;
    end else if (cap_en) begin
      sel_q  <= sel_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      opa_q  <= opa_d;
      opb_q  <= opb_d;
      old_q  <= old_d;
    end
  end

  always_comb begin
    req_gnt   = rst_i_n ? gnt : '0;
    rsp_valid = '0;
    rsp_data  = '0;
    rsp_ok    = 1'b0;
    if (in_write) begin
      rsp_valid[sel_q] = 1'b1;
      rsp_data         = old_q;
      rsp_ok           = alu_ok;
    end
  end

  // R2
  rsp_follows_gnt_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|req_gnt) |=> (rsp_valid == $past(req_gnt)));

  // R2
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(rsp_valid));

  // R11
  no_gnt_in_write_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|rsp_valid) |-> (req_gnt == '0));

  // R9
  cas_fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((|rsp_valid) && !rsp_ok) |-> !mem_we);

  // R2
  write_only_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_we |-> (|rsp_valid));
endmodule

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;
  localparam int N  = 4;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic [1:0]    who;
    logic [DW-1:0] data;
    logic          ok;
  } exp_t;

  logic clk;
  logic rst_n;
  logic [N-1:0]    req_valid;
  logic [N*3-1:0]  req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_opa;
  logic [N*DW-1:0] req_opb;
  logic [N-1:0]    req_gnt;
  logic [N-1:0]    rsp_valid;
  logic [DW-1:0]   rsp_data;
  logic            rsp_ok;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  exp_t exp_q [$];
  logic [DW-1:0] mdl [DEPTH];
  int ptr = 0;

  atomic_rmw_unit u_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_opa(req_opa), .req_opb(req_opb),
    .req_gnt(req_gnt), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_ok(rsp_ok)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model from the requirements; pushes the expected response
  task automatic push_op(input int r, input logic [2:0] op, input int addr,
                         input logic [DW-1:0] a, input logic [DW-1:0] b);
    exp_t e;
    logic [DW-1:0] old;
    old = mdl[addr];
    e.who = 2'(r);
    e.data = old;
    e.ok = 1'b1;
    case (op)
      3'b001, 3'b011: mdl[addr] = a;
      3'b010: if (old == '0) mdl[addr] = 1;
      3'b100: mdl[addr] = old + a;
      3'b101: begin
        if (old == a) mdl[addr] = b;
        else e.ok = 1'b0;
      end
      default: ;
    endcase
    ptr = (r + 1) % N;
    exp_q.push_back(e);
  endtask

  task automatic drive(input int r, input logic [2:0] op, input int addr,
                       input logic [DW-1:0] a, input logic [DW-1:0] b);
    req_op[r*3 +: 3]    = op;
    req_addr[r*AW +: AW] = AW'(addr);
    req_opa[r*DW +: DW]  = a;
    req_opb[r*DW +: DW]  = b;
    req_valid[r] = 1'b1;
    while (1) begin
      #1;
      if (req_gnt[r]) break;
      @(negedge clk);
    end
    @(negedge clk);
    #1;
    check(rsp_valid[r] == 1'b1, "R2 response one cycle after grant", 64'(rsp_valid), 64'(1 << r));
    check(req_gnt == '0, "R11 no grant during write cycle", 64'(req_gnt), 64'h0);
    req_valid[r] = 1'b0;
  endtask

  task automatic run_op(input int r, input logic [2:0] op, input int addr,
                        input logic [DW-1:0] a, input logic [DW-1:0] b);
    push_op(r, op, addr, a, b);
    @(negedge clk);
    drive(r, op, addr, a, b);
  endtask

  // all requesters in mask issue fetch-and-add by 1 to addr on the same edge
  task automatic burst(input logic [N-1:0] mask, input int addr);
    int start;
    start = ptr;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (start + k) % N;
      if (mask[idx]) push_op(idx, 3'b100, addr, 1, 0);
    end
    @(negedge clk);
    fork
      if (mask[0]) drive(0, 3'b100, addr, 1, 0);
      if (mask[1]) drive(1, 3'b100, addr, 1, 0);
      if (mask[2]) drive(2, 3'b100, addr, 1, 0);
      if (mask[3]) drive(3, 3'b100, addr, 1, 0);
    join
  endtask

  // monitor: pops the scoreboard on each response
  always @(negedge clk) begin
    #3;
    if (rst_n && (|rsp_valid)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", 64'(rsp_valid), 64'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_valid == N'(1 << e.who), "R10 response requester order", 64'(rsp_valid), 64'(1 << e.who));
        check(rsp_data == e.data, "R3-R9 returned old word", 64'(rsp_data), 64'(e.data));
        check(rsp_ok == e.ok, "R9 status bit", 64'(rsp_ok), 64'(e.ok));
      end
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    rst_n = 1'b0;
    req_valid = '0;
    req_op = '0;
    req_addr = '0;
    req_opa = '0;
    req_opb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1
    check(req_gnt == '0, "R1 no grant after reset", 64'(req_gnt), 64'h0);
    check(rsp_valid == '0, "R1 no response after reset", 64'(rsp_valid), 64'h0);
    run_op(0, 3'b000, 0, 0, 0);   // R1 R3 zero word
    run_op(1, 3'b000, 15, 0, 0);  // R1
    // R4 store then R3 load
    run_op(2, 3'b001, 3, 32'h0000_A5A5, 0);
    run_op(3, 3'b000, 3, 0, 0);
    run_op(0, 3'b000, 3, 0, 0);   // R3 load left word intact
    // R5 test-and-set
    run_op(1, 3'b010, 4, 0, 0);
    run_op(1, 3'b010, 4, 0, 0);
    run_op(2, 3'b000, 4, 0, 0);
    run_op(2, 3'b010, 3, 0, 0);
    run_op(3, 3'b000, 3, 0, 0);
    // R6 swap
    run_op(0, 3'b011, 3, 32'h0000_1234, 0);
    run_op(1, 3'b000, 3, 0, 0);
    // R7 fetch-and-add wrap
    run_op(2, 3'b001, 6, 32'hFFFF_FFFE, 0);
    run_op(3, 3'b100, 6, 32'd5, 0);
    run_op(0, 3'b000, 6, 0, 0);
    // R8 compare-and-swap success, R9 mismatch
    run_op(1, 3'b101, 6, 32'd3, 32'd9);
    run_op(2, 3'b000, 6, 0, 0);
    run_op(3, 3'b101, 6, 32'd3, 32'd7);
    run_op(0, 3'b000, 6, 0, 0);
    // R12 unused opcodes act as load
    run_op(1, 3'b110, 6, 32'd44, 32'd55);
    run_op(2, 3'b111, 6, 32'd66, 32'd77);
    run_op(3, 3'b000, 6, 0, 0);
    // R10 R11 contention: pointer now at requester 0
    burst(4'b1111, 8);
    run_op(1, 3'b000, 8, 0, 0);   // R11 all four increments land
    // pointer at 2; steer to 3 then sparse burst from 0 and 2
    run_op(2, 3'b000, 0, 0, 0);
    burst(4'b0101, 9);
    run_op(3, 3'b000, 9, 0, 0);   // R10
    burst(4'b1010, 9);
    run_op(0, 3'b000, 9, 0, 0);   // R11 count
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 every expected response seen", 64'(exp_q.size()), 64'h0);
    check(mdl[8] == 32'd4, "R11 model counter", 64'(mdl[8]), 64'd4);
    finish_run();
  end
endmodule